// File: doc/BRIEF.md
# Element-Width-Selectable SIMD Vector ALU

The block executes one element-wise arithmetic, logic or shift operation on two vector registers. Each register holds K slices of 32 bits, and the element width is chosen per operation as 8, 16, 32 or 64 bits. The datapath is built from K/2 lane-pair units. Inside each pair, carries, borrows and shifted bits stay within the boundaries of the selected element. In 64-bit mode the carry runs from the low slice into the high slice of the pair, but never into the next pair.

A 20-bit operation word selects the class, width, opcode, destination and two sources. The register file is modelled inside the block as a plain array. A load port fills it, and a read port brings any register out. The result is registered. Result, destination index and a write strobe appear one cycle after the operation is accepted, and the register file is updated on that same edge.

Top module: `vec_simd_alu`

## Requirements
- R1: Operation word fields are op_i[19:18] class, [17:16] width code, [15:12] opcode, [11:8] destination, [7:4] first source, [3:0] second source. Only class 01 executes. When op_valid_i is sampled high with an executable operation, the next cycle shows wr_o=1, dst_o=destination and res_o=result, and the destination register holds the result.
- R2: Width code 00/01/10/11 selects 8/16/32/64-bit elements. Opcode 0000 adds element-wise modulo 2^width, and no carry passes out of an element.
- R3: Opcode 0010 subtracts the second source from the first element-wise modulo 2^width, and no borrow crosses an element boundary.
- R4: In 64-bit mode the carry propagates from bit 31 into bit 32 of each slice pair, and no carry passes from one pair into the next.
- R5: Opcodes 1000/1001/1010 give bitwise AND/OR/XOR, and the result does not depend on the width code.
- R6: Opcode 1100 shifts each element left by one bit and inserts zero at its lowest bit.
- R7: Opcode 1110 shifts each element right by one bit and inserts zero at its highest bit.
- R8: Opcode 1011, when parameter HAS_MUL is 1, yields the low width bits of each element-wise product.
- R9: A class other than 01 (class 00 is the vector no-op) writes nothing: wr_o stays 0, and res_o, dst_o and all registers keep their values.
- R10: A class-01 operation with an opcode not listed in R2-R8 (or 1011 with HAS_MUL=0) writes nothing and leaves res_o and dst_o unchanged.
- R11: After reset all registers, res_o and dst_o are zero and wr_o is 0.
- R12: ld_en_i writes ld_data_i to register ld_idx_i on the clock edge. If an executing operation targets the same register in the same cycle, the operation result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation word valid this cycle |
| op_i | input | 20 | Vector operation word |
| ld_en_i | input | 1 | Register load enable |
| ld_idx_i | input | 4 | Register load index |
| ld_data_i | input | K*32 | Register load data |
| rd_idx_i | input | 4 | Register read index |
| rd_data_o | output | K*32 | Register read data (combinational) |
| res_o | output | K*32 | Registered result of the last executed operation |
| dst_o | output | 4 | Destination index of the last executed operation |
| wr_o | output | 1 | Result written this cycle |

## Verification
On every cycle, assertions check the strobe and destination timing for executable operations. They also check that no write follows a no-op class or an unlisted opcode, that res_o holds when nothing executes, and that bitwise AND matches its operands. The element-boundary behaviour of add, subtract, shift and multiply at each of the four widths, the pair boundary in 64-bit mode, and the load-versus-operation collision are shown only by the bench scenarios. Those scenarios compare the results against an element-by-element reference model.

// File: rtl/vec_simd_pkg.sv
package vec_simd_pkg;
  localparam int NREG  = 16;
  localparam int IDX_W = 4;

  typedef enum logic [1:0] {EW8 = 2'b00, EW16 = 2'b01, EW32 = 2'b10, EW64 = 2'b11} ew_e;

  localparam logic [1:0] CLS_ALU = 2'b01;
  localparam logic [3:0] OPC_ADD = 4'b0000;
  localparam logic [3:0] OPC_SUB = 4'b0010;
  localparam logic [3:0] OPC_AND = 4'b1000;
  localparam logic [3:0] OPC_OR  = 4'b1001;
  localparam logic [3:0] OPC_XOR = 4'b1010;
  localparam logic [3:0] OPC_MUL = 4'b1011;
  localparam logic [3:0] OPC_SHL = 4'b1100;
  localparam logic [3:0] OPC_SHR = 4'b1110;

  // byte j of a 64-bit pair begins an element
  function automatic logic elem_start(ew_e ew, logic [2:0] j);
    case (ew)
      EW8:     return 1'b1;
      EW16:    return j[0] == 1'b0;
      EW32:    return j[1:0] == 2'b00;
      default: return j == 3'd0;
    endcase
  endfunction

  function automatic logic elem_end(ew_e ew, logic [2:0] j);
    if (j == 3'd7) return 1'b1;
    return elem_start(ew, j + 3'd1);
  endfunction

  function automatic logic opc_listed(logic [3:0] opc, bit has_mul);
    case (opc)
      OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_XOR, OPC_SHL, OPC_SHR: return 1'b1;
      OPC_MUL: return has_mul;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/vec_regfile.sv
module vec_regfile #(
  parameter int DW   = 128,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] ra_idx_i,
  input  logic [IW-1:0] rb_idx_i,
  input  logic [IW-1:0] rc_idx_i,
  output logic [DW-1:0] ra_o,
  output logic [DW-1:0] rb_o,
  output logic [DW-1:0] rc_o,
  input  logic          alu_we_i,
  input  logic [IW-1:0] alu_idx_i,
  input  logic [DW-1:0] alu_d_i,
  input  logic          ld_we_i,
  input  logic [IW-1:0] ld_idx_i,
  input  logic [DW-1:0] ld_d_i
);
  logic [DW-1:0] mem_q [NREG];

  assign ra_o = mem_q[ra_idx_i];
  assign rb_o = mem_q[rb_idx_i];
  assign rc_o = mem_q[rc_idx_i];

  // ALU write is last, so it wins on an index collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else begin
      if (ld_we_i)  mem_q[ld_idx_i]  <= ld_d_i;
      if (alu_we_i) mem_q[alu_idx_i] <= alu_d_i;
    end
  end
endmodule

// File: rtl/vec_pair_alu.sv
module vec_pair_alu
  import vec_simd_pkg::*;
#(
  parameter bit HAS_MUL = 1'b1
) (
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  input  ew_e         ew_i,
  input  logic [3:0]  opc_i,
  output logic [63:0] y_o
);
  logic [63:0] sum, shl, shr, mul;

  // byte-sliced adder; carry restarts at each element start
  always_comb begin
    logic       c, sub, cin;
    logic [8:0] t;
    sub = (opc_i == OPC_SUB);
    c   = 1'b0;
    sum = '0;
    for (int j = 0; j < 8; j++) begin
      cin = elem_start(ew_i, 3'(j)) ? sub : c;
      t   = {1'b0, a_i[j*8 +: 8]} + {1'b0, b_i[j*8 +: 8] ^ {8{sub}}} + {8'd0, cin};
      sum[j*8 +: 8] = t[7:0];
      c   = t[8];
    end
  end

  always_comb begin
    logic [63:0] al, ar;
    al  = a_i << 1;
    ar  = a_i >> 1;
    shl = al;
    shr = ar;
    for (int j = 0; j < 8; j++) begin
      if (elem_start(ew_i, 3'(j))) shl[j*8]     = 1'b0;
      if (elem_end(ew_i, 3'(j)))   shr[j*8 + 7] = 1'b0;
    end
  end

  generate
    if (HAS_MUL) begin : g_mul
      logic [63:0] m8, m16, m32, m64;
      for (genvar g = 0; g < 8; g++) begin : g_m8
        assign m8[g*8 +: 8] = a_i[g*8 +: 8] * b_i[g*8 +: 8];
      end
      for (genvar g = 0; g < 4; g++) begin : g_m16
        assign m16[g*16 +: 16] = a_i[g*16 +: 16] * b_i[g*16 +: 16];
      end
      for (genvar g = 0; g < 2; g++) begin : g_m32
        assign m32[g*32 +: 32] = a_i[g*32 +: 32] * b_i[g*32 +: 32];
      end
      assign m64 = a_i * b_i;
      always_comb begin
        case (ew_i)
          EW8:     mul = m8;
          EW16:    mul = m16;
          EW32:    mul = m32;
          default: mul = m64;
        endcase
      end
    end else begin : g_nomul
      assign mul = '0;
    end
  endgenerate

  always_comb begin
    case (opc_i)
      OPC_ADD, OPC_SUB: y_o = sum;
      OPC_AND:          y_o = a_i & b_i;
      OPC_OR:           y_o = a_i | b_i;
      OPC_XOR:          y_o = a_i ^ b_i;
      OPC_MUL:          y_o = mul;
      OPC_SHL:          y_o = shl;
      OPC_SHR:          y_o = shr;
      default:          y_o = '0;
    endcase
  end
endmodule

// File: rtl/vec_simd_alu.sv
module vec_simd_alu
  import vec_simd_pkg::*;
#(
  parameter int K       = 4,
  parameter bit HAS_MUL = 1'b1,
  localparam int DW     = K * 32,
  localparam int NPAIR  = K / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [19:0]      op_i,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [DW-1:0]    ld_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [DW-1:0]    res_o,
  output logic [IDX_W-1:0] dst_o,
  output logic             wr_o
);
  logic [1:0]       cls;
  ew_e              ew;
  logic [3:0]       opc;
  logic [IDX_W-1:0] d_idx, v_idx, w_idx;
  logic [DW-1:0]    va, vb, y;
  logic             exec;

  assign cls   = op_i[19:18];
  assign ew    = ew_e'(op_i[17:16]);
  assign opc   = op_i[15:12];
  assign d_idx = op_i[11:8];
  assign v_idx = op_i[7:4];
  assign w_idx = op_i[3:0];
  assign exec  = op_valid_i && (cls == CLS_ALU) && opc_listed(opc, HAS_MUL);

  vec_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_idx_i (v_idx),
    .rb_idx_i (w_idx),
    .rc_idx_i (rd_idx_i),
    .ra_o     (va),
    .rb_o     (vb),
    .rc_o     (rd_data_o),
    .alu_we_i (exec),
    .alu_idx_i(d_idx),
    .alu_d_i  (y),
    .ld_we_i  (ld_en_i),
    .ld_idx_i (ld_idx_i),
    .ld_d_i   (ld_data_i)
  );

  generate
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      vec_pair_alu #(.HAS_MUL(HAS_MUL)) u_pair (
        .a_i  (va[p*64 +: 64]),
        .b_i  (vb[p*64 +: 64]),
        .ew_i (ew),
        .opc_i(opc),
        .y_o  (y[p*64 +: 64])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o  <= 1'b0;
      res_o <= '0;
      dst_o <= '0;
    end else begin
      wr_o <= exec;
      if (exec) begin
        res_o <= y;
        dst_o <= d_idx;
      end
    end
  end

  AST_EXEC_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && cls == CLS_ALU && opc_listed(opc, HAS_MUL)) |=> (wr_o && dst_o == $past(op_i[11:8]))); // R1
  AST_NOP_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && cls != CLS_ALU) |=> !wr_o); // R9
  AST_UNLISTED_OPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && cls == CLS_ALU && !opc_listed(opc, HAS_MUL)) |=> !wr_o); // R10
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_o |-> $stable(res_o)); // R9
  AST_AND_BITWISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && opc == OPC_AND) |=> (res_o == $past(va & vb))); // R5
  AST_K_EVEN: assert final ((K % 2) == 0 && K >= 2); // R4
endmodule

// File: tb/vec_simd_alu_tb.sv
`timescale 1ns/1ps
module vec_simd_alu_tb;
  localparam int K  = 4;
  localparam int DW = K * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [19:0]   op = '0;
  logic          ld_en = 1'b0;
  logic [3:0]    ld_idx = '0;
  logic [DW-1:0] ld_data = '0;
  logic [3:0]    rd_idx = '0;
  logic [DW-1:0] rd_data, res;
  logic [3:0]    dst;
  logic          wr;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] shadow [16];
  logic [DW-1:0] last_res = '0;
  logic [3:0]    last_dst = '0;

  always #2 clk = ~clk;

  vec_simd_alu #(.K(K), .HAS_MUL(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .ld_en_i(ld_en), .ld_idx_i(ld_idx), .ld_data_i(ld_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .res_o(res), .dst_o(dst), .wr_o(wr)
  );

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_op(input logic [1:0] ww, input logic [3:0] opc,
                                           input logic [DW-1:0] a, input logic [DW-1:0] b);
    int ew;
    logic [63:0] mask, ea, eb, r;
    logic [DW-1:0] out;
    ew   = 8 << ww;
    mask = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
    out  = '0;
    for (int i = 0; i < DW / ew; i++) begin
      ea = 64'(a >> (i * ew)) & mask;
      eb = 64'(b >> (i * ew)) & mask;
      case (opc)
        4'b0000: r = ea + eb;
        4'b0010: r = ea - eb;
        4'b1000: r = ea & eb;
        4'b1001: r = ea | eb;
        4'b1010: r = ea ^ eb;
        4'b1011: r = ea * eb;
        4'b1100: r = ea << 1;
        default: r = ea >> 1;
      endcase
      out = out | (DW'(r & mask) << (i * ew));
    end
    return out;
  endfunction

  function automatic bit listed(input logic [3:0] opc);
    return opc inside {4'b0000, 4'b0010, 4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1110};
  endfunction

  task automatic load(input logic [3:0] idx, input logic [DW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    shadow[idx] = d;
  endtask

  task automatic read_chk(input string req, input logic [3:0] idx);
    rd_idx = idx;
    #0.1;
    chk(req, rd_data, shadow[idx]);
  endtask

  // issue one operation and check strobe, outputs and destination register
  task automatic run_op(input string req, input logic [1:0] cls, input logic [1:0] ww,
                        input logic [3:0] opc, input logic [3:0] d, input logic [3:0] v,
                        input logic [3:0] w);
    logic do_wr;
    logic [DW-1:0] exp;
    do_wr = (cls == 2'b01) && listed(opc);
    exp   = ref_op(ww, opc, shadow[v], shadow[w]);
    @(negedge clk);
    op_valid = 1'b1; op = {cls, ww, opc, d, v, w};
    @(negedge clk);
    op_valid = 1'b0;
    if (do_wr) begin
      shadow[d] = exp;
      last_res  = exp;
      last_dst  = d;
    end
    chk({req, " wr"}, DW'(wr), DW'(do_wr));
    chk({req, " res"}, res, last_res);
    chk({req, " dst"}, DW'(dst), DW'(last_dst));
    read_chk({req, " reg"}, d);
  endtask

  localparam logic [DW-1:0] VA = 128'h8000_0000_FFFF_FFFF_7FFF_80FF_01FF_00FE;
  localparam logic [DW-1:0] VB = 128'h0000_0001_0000_0001_0001_8001_FF01_0102;
  localparam logic [DW-1:0] VC = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F0F0_0F0F;
  localparam logic [DW-1:0] VD = 128'h1357_9BDF_2468_ACE0_FFFF_0000_AAAA_5555;

  task automatic t_reset();
    chk("R11 wr", DW'(wr), '0);
    chk("R11 res", res, '0);
    chk("R11 dst", DW'(dst), '0);
    for (int i = 0; i < 16; i++) read_chk("R11 reg", 4'(i));
  endtask

  task automatic t_load();
    load(4'd1, VA); load(4'd2, VB); load(4'd3, VC); load(4'd4, VD);
    load(4'd5, '1); load(4'd6, 128'd1);
    for (int i = 1; i <= 6; i++) read_chk("R12 load", 4'(i));
  endtask

  task automatic t_add();
    for (int ww = 0; ww < 4; ww++) run_op("R2 add", 2'b01, 2'(ww), 4'b0000, 4'd8, 4'd1, 4'd2);
    for (int ww = 0; ww < 4; ww++) run_op("R2 add cd", 2'b01, 2'(ww), 4'b0000, 4'd9, 4'd3, 4'd4);
    run_op("R1 dest is source", 2'b01, 2'b00, 4'b0000, 4'd9, 4'd9, 4'd2);
  endtask

  task automatic t_sub();
    for (int ww = 0; ww < 4; ww++) run_op("R3 sub", 2'b01, 2'(ww), 4'b0010, 4'd8, 4'd2, 4'd1);
    for (int ww = 0; ww < 4; ww++) run_op("R3 sub cd", 2'b01, 2'(ww), 4'b0010, 4'd10, 4'd4, 4'd3);
  endtask

  task automatic t_pair();
    // all-ones + 1: carry ripples through a pair, stops at the pair edge
    run_op("R4 pair edge", 2'b01, 2'b11, 4'b0000, 4'd11, 4'd5, 4'd6);
    chk("R4 upper pair", res, {64'hFFFF_FFFF_FFFF_FFFF, 64'd0});
    run_op("R4 32-bit no cross", 2'b01, 2'b10, 4'b0000, 4'd11, 4'd5, 4'd6);
    chk("R4 lane only", res, {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'd0});
    run_op("R4 borrow pair", 2'b01, 2'b11, 4'b0010, 4'd12, 4'd6, 4'd5);
  endtask

  task automatic t_logic();
    for (int ww = 0; ww < 4; ww++) begin
      run_op("R5 and", 2'b01, 2'(ww), 4'b1000, 4'd8, 4'd3, 4'd4);
      run_op("R5 or", 2'b01, 2'(ww), 4'b1001, 4'd8, 4'd3, 4'd4);
      run_op("R5 xor", 2'b01, 2'(ww), 4'b1010, 4'd8, 4'd3, 4'd4);
    end
  endtask

  task automatic t_shift();
    for (int ww = 0; ww < 4; ww++) begin
      run_op("R6 shl", 2'b01, 2'(ww), 4'b1100, 4'd13, 4'd1, 4'd0);
      run_op("R6 shl ones", 2'b01, 2'(ww), 4'b1100, 4'd13, 4'd5, 4'd0);
      run_op("R7 shr", 2'b01, 2'(ww), 4'b1110, 4'd14, 4'd3, 4'd0);
      run_op("R7 shr ones", 2'b01, 2'(ww), 4'b1110, 4'd14, 4'd5, 4'd0);
    end
  endtask

  task automatic t_mul();
    for (int ww = 0; ww < 4; ww++) begin
      run_op("R8 mul", 2'b01, 2'(ww), 4'b1011, 4'd15, 4'd3, 4'd4);
      run_op("R8 mul ab", 2'b01, 2'(ww), 4'b1011, 4'd15, 4'd1, 4'd5);
    end
  endtask

  task automatic t_nop();
    run_op("R9 vnop", 2'b00, 2'b00, 4'b0000, 4'd1, 4'd3, 4'd4);
    run_op("R9 class10", 2'b10, 2'b10, 4'b0000, 4'd2, 4'd3, 4'd4);
    run_op("R9 class11", 2'b11, 2'b01, 4'b1000, 4'd3, 4'd1, 4'd4);
    read_chk("R9 src kept", 4'd1);
  endtask

  task automatic t_unlisted();
    run_op("R10 op0001", 2'b01, 2'b00, 4'b0001, 4'd1, 4'd3, 4'd4);
    run_op("R10 op0111", 2'b01, 2'b10, 4'b0111, 4'd2, 4'd3, 4'd4);
    run_op("R10 op1111", 2'b01, 2'b11, 4'b1111, 4'd4, 4'd1, 4'd2);
  endtask

  task automatic t_collide();
    logic [DW-1:0] exp;
    exp = ref_op(2'b10, 4'b1010, shadow[3], shadow[4]);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 4'd7; ld_data = VA;
    op_valid = 1'b1; op = {2'b01, 2'b10, 4'b1010, 4'd7, 4'd3, 4'd4};
    @(negedge clk);
    ld_en = 1'b0; op_valid = 1'b0;
    shadow[7] = exp;
    read_chk("R12 collision", 4'd7);
  endtask

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    #1;
    t_reset();
    #10 rst_n = 1'b1;
    t_load();
    t_add();
    t_sub();
    t_pair();
    t_logic();
    t_shift();
    t_mul();
    t_nop();
    t_unlisted();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule